// File: doc/BRIEF.md
# Change-Detect Interrupt Status Bank

This block keeps one sticky status register for each of four line channels. Each channel feeds in seven live condition levels. These are driver monitor, elastic-store nearness, line code violation, network loop-code detect, alarm indication signal detect, receive loss of signal, and pseudo-random pattern detect. The elastic-store nearness level is high when the store's read and write pointers are within three positions of each other. The block samples every level on each clock. When a level moves in either direction, the block sets the matching sticky bit.

Software reads a channel's register over a small synchronous read port. The read returns the gathered bits one cycle later and clears them in the same step. Each channel drives an interrupt line that is high while any of its bits are set. A combined line is high while any channel has a pending bit. The condition levels are taken as synchronous to the block clock.

Top module: `chg_irq_status`

## Requirements
- R1: After reset, `rdata_o`, every sticky bit, `irq_o` and `irq_any_o` are 0.
- R2: A 0-to-1 change on a condition input sets its sticky bit in the clock edge that first samples the new level. Within `stat_i[c*7 +: 7]`, bit 6 is driver monitor, 5 elastic-store nearness, 4 code violation, 3 loop-code detect, 2 alarm indication, 1 loss of signal and 0 pattern detect, and the register bit takes the same position.
- R3: A 1-to-0 change on a condition input sets its sticky bit in the same way as a rising change.
- R4: A set bit holds until its register is read. A read with `rd_en_i` high at one edge presents the bits on `rdata_o[6:0]` after that edge, and `rdata_o[7]` is always 0.
- R5: A read clears only the addressed channel's bits. The other channels keep their pending bits.
- R6: Channel c is decoded at address `{1'b0, c[1:0], 4'b0110}`. A read at any other address returns 0 and clears nothing.
- R7: If a change arrives in the same cycle as a read of its channel, the read returns the bits held before the change. The new change stays latched for the next read.
- R8: `irq_o[c]` is the OR of channel c's seven sticky bits, and `irq_any_o` is the OR of all `irq_o` bits.
- R9: The level present on an input when reset is released does not count as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_i | input | 28 | Live condition levels, seven per channel, channel c at bits [c*7 +: 7] |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | 7 | Register address |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| irq_o | output | 4 | Per-channel pending interrupt |
| irq_any_o | output | 1 | OR of all channel interrupts |

## Verification
The assertions assume the condition levels are already synchronous to `clk_i` and settle before each edge. They also assume `rd_en_i` and `addr_i` are stable around the edge. The bench changes every input on the falling clock edge, so each level is steady when the rising edge samples it. The bench pulses the read strobe for one cycle at a time, with the address held for the whole strobe.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned SRC_W    = 7;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned CH_SEL_W = $clog2(NUM_CH);
  localparam int unsigned OFS_W    = 4;
  localparam logic [OFS_W-1:0] REG_OFS = 4'b0110;
endpackage

// File: rtl/chg_irq_edge.sv
module chg_irq_edge #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] samp_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      samp_q   <= stat_i;
      primed_q <= 1'b1;
    end
  end

  // first sample after reset only seeds the history
  assign chg_o = (stat_i ^ samp_q) & {W{primed_q}};

  AST_NO_CHG_UNPRIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> chg_o == '0) else $error("edge flagged before priming"); // R9
endmodule

// File: rtl/chg_irq_sticky.sv
module chg_irq_sticky #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~{W{clr_i}}) | chg_i;
  end

  assign flags_o = flags_q;

  for (genvar b = 0; b < W; b++) begin : g_ast
    AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chg_i[b] |=> flags_q[b]) else $error("change lost"); // R2
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[b] && !clr_i) |=> flags_q[b]) else $error("flag dropped"); // R4
    AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !chg_i[b]) |=> !flags_q[b]) else $error("flag survived read"); // R5
  end
endmodule

// File: rtl/chg_irq_decode.sv
module chg_irq_decode
  import chg_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] hit_o
);
  logic base_ok;

  assign base_ok = rd_en_i && (addr_i[OFS_W-1:0] == REG_OFS)
                && (addr_i[ADDR_W-1:OFS_W+CH_SEL_W] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign hit_o[c] = base_ok && (addr_i[OFS_W +: CH_SEL_W] == CH_SEL_W'(c));
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)) else $error("multiple channels decoded"); // R6
  AST_HIT_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> hit_o == '0) else $error("decode without strobe"); // R6
endmodule

// File: rtl/chg_irq_status.sv
module chg_irq_status
  import chg_irq_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*SRC_W-1:0] stat_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]       irq_o,
  output logic                    irq_any_o
);
  logic [NUM_CH-1:0]            hit;
  logic [NUM_CH-1:0][SRC_W-1:0] chg;
  logic [NUM_CH-1:0][SRC_W-1:0] flags;
  logic [SRC_W-1:0]             sel_data;
  logic [DATA_W-1:0]            rdata_q;

  chg_irq_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chg_irq_edge #(.W(SRC_W)) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stat_i(stat_i[c*SRC_W +: SRC_W]),
      .chg_o (chg[c])
    );
    chg_irq_sticky #(.W(SRC_W)) u_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .chg_i  (chg[c]),
      .clr_i  (hit[c]),
      .flags_o(flags[c])
    );
    assign irq_o[c] = |flags[c];
  end

  always_comb begin
    sel_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) sel_data |= flags[c];
    end
  end

  // snapshot taken before the clear lands: same-cycle events go to the next read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= {{(DATA_W-SRC_W){1'b0}}, sel_data};
  end

  assign rdata_o   = rdata_q;
  assign irq_any_o = |irq_o;

  AST_UNDEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |=> rdata_o == '0) else $error("data on undecoded read"); // R6
  AST_READ_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> rdata_o[SRC_W-1:0] == $past(sel_data)) else $error("read data mismatch"); // R7
  AST_RSVD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> !rdata_o[DATA_W-1]) else $error("reserved bit set"); // R4
endmodule

// File: tb/chg_irq_status_tb.sv
module chg_irq_status_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] stat = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  rdata;
  logic [3:0]  irq;
  logic        irq_any;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_irq_status dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .stat_i   (stat),
    .rd_en_i  (rd_en),
    .addr_i   (addr),
    .rdata_o  (rdata),
    .irq_o    (irq),
    .irq_any_o(irq_any)
  );

  function automatic logic [6:0] ch_addr(input int c);
    return {1'b0, 2'(c), 4'b0110};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flip(input int c, input int b);
    @(negedge clk);
    stat[c*7+b] = ~stat[c*7+b];
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    stat[0*7+3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {4'b0, irq}, 8'h00);
    check("R1 irq_any", {7'b0, irq_any}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(ch_addr(0), d);
    check("R9 level at reset", d, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    flip(1, 6);
    @(negedge clk);
    check("R8 irq ch1", {4'b0, irq}, 8'h02);
    rd(ch_addr(1), d);
    check("R2 rise bit6", d, 8'h40);
    rd(ch_addr(1), d);
    check("R5 cleared", d, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    flip(1, 6);
    rd(ch_addr(1), d);
    check("R3 fall bit6", d, 8'h40);
    flip(0, 3);
    rd(ch_addr(0), d);
    check("R3 fall bit3", d, 8'h08);
  endtask

  task automatic t_hold_isolate();
    logic [7:0] d;
    flip(2, 0);
    flip(2, 1);
    flip(3, 5);
    repeat (5) @(negedge clk);
    rd(ch_addr(2), d);
    check("R4 held bits", d, 8'h03);
    check("R5 ch3 kept", {4'b0, irq}, 8'h08);
    rd(ch_addr(3), d);
    check("R5 ch3 read", d, 8'h20);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    flip(0, 2);
    rd(7'b1000110, d);
    check("R6 bit6 set", d, 8'h00);
    rd(7'b0000111, d);
    check("R6 bad offset", d, 8'h00);
    check("R6 nothing cleared", {4'b0, irq}, 8'h01);
    rd(ch_addr(0), d);
    check("R6 good addr", d, 8'h04);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    flip(1, 4);
    @(negedge clk);
    stat[1*7+1] = ~stat[1*7+1];
    addr  = ch_addr(1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 old value", rdata, 8'h10);
    rd(ch_addr(1), d);
    check("R7 new kept", d, 8'h02);
  endtask

  task automatic t_irq();
    @(negedge clk);
    check("R8 all idle", {3'b0, irq_any, irq}, 8'h00);
    flip(3, 0);
    @(negedge clk);
    check("R8 any", {3'b0, irq_any, irq}, 8'h18);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WD_CYCLES; i++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_hold_isolate();
    t_decode();
    t_collide();
    t_irq();
    done = 1'b1;
    finish_run();
  end
endmodule